// File: doc/BRIEF.md
# Parallel Display Write Streamer

This block moves a run of words from a synchronous memory read port onto the parallel data pins of a display panel. Each word gets one write strobe. Software supplies a start address, a word count, a bus width mode and a strobe period, then pulses `start`. The block latches these settings, fetches the words in address order and drives each one onto the panel bus. It pulses the strobe at a rate set by the period value, so a slow panel can keep up.

The panel captures each word on the falling edge of the strobe. The next word is placed on the bus on the rising edge, so the data is stable for the whole high phase. It stays on the bus through the following low phase as hold time. The panel can hold off the next strobe by driving its ready input low. One sticky interrupt marks the end of the whole run; no interrupt is raised per word.

The memory port is read with a one-cycle latency. The memory's output must hold its last read value until the next read is issued, as a block RAM output register does.

Top module: `pdisp_stream`

## Requirements
- R1: After reset, `pnl_wr`, `pnl_data`, `mem_rd`, `busy` and `irq` are all low.
- R2: A `start` pulse with a non-zero `cfg_count` raises `busy` on the next clock, and `busy` stays high until the run completes. A `start` pulse received while `busy` is high has no effect on the run in progress.
- R3: A run of N words produces exactly N strobe pulses. The k-th pulse carries the word read from address `cfg_addr + k` (k counting from 0, wrapping modulo 2^AW). `mem_rd` is only asserted while `busy` is high.
- R4: `pnl_data` changes only in the cycle in which `pnl_wr` rises. It holds its value through the high phase and the following low phase.
- R5: With period value P latched at start, each strobe high phase lasts exactly P+1 clocks. Each low phase between two strobes also lasts P+1 clocks while `pnl_ready` is high.
- R6: `cfg_mode` 0 drives `mem_rdata[7:0]` on the bus, 1 drives `[15:0]`, and 2 or 3 drives all 32 bits. Data lines above the selected width are driven to zero.
- R7: `pnl_wr` rises only if `pnl_ready` was high at the preceding clock edge. While `pnl_ready` stays low, no further strobe is issued and `busy` remains high.
- R8: `busy` falls and `irq` rises in the same cycle, P+1 clocks after the last falling strobe edge. `irq` stays low throughout the run.
- R9: A `start` with `cfg_count` of zero sets `irq` on the next clock. It issues no memory read and no strobe, and `busy` stays low.
- R10: `irq` stays high until `irq_clr` is pulsed. If `irq_clr` and a completion fall in the same cycle, the completion wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| cfg_addr | input | AW | First source word address |
| cfg_count | input | CW | Number of words in the run |
| cfg_mode | input | 2 | Bus width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| cfg_period | input | PW | Strobe phase length minus one, in clocks |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |
| mem_rd | output | 1 | Memory read enable |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` and held until the next read |
| pnl_ready | input | 1 | Panel can accept another word |
| pnl_data | output | DW | Panel data bus |
| pnl_wr | output | 1 | Panel write strobe, captured on its falling edge |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Sticky completion interrupt |

## Verification
Some rules can be judged in every cycle, and the assertions check these. The data bus moves only on a strobe rising edge, and a rising edge never follows a cycle with ready low. Strobes and reads occur only while busy. Completion coincides with the interrupt, and the interrupt stays set until it is cleared. Other behaviour spans a whole run, so only the bench scenarios can show it. This covers the exact phase lengths for each period value, the word order and address wrap, and the lane masking per width mode. It also covers the total strobe count, the zero-count run, a start ignored mid-run, and a run held off by ready.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } pd_state_t;

  localparam logic [1:0] MODE_W8  = 2'd0;
  localparam logic [1:0] MODE_W16 = 2'd1;
endpackage

// File: rtl/pdisp_phase_timer.sv
module pdisp_phase_timer #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt;

  // Counts 0..period and saturates; tick marks the last cycle of a phase.
  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt != period) cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == period);
endmodule

// File: rtl/pdisp_bus_pack.sv
module pdisp_bus_pack
  import pdisp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic [1:0]    mode,
  output logic [DW-1:0] dout
);
  localparam int NL = DW / 8;

  int unsigned lanes;

  always_comb begin
    case (mode)
      MODE_W8:  lanes = 1;
      MODE_W16: lanes = 2;
      default:  lanes = NL;
    endcase
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign dout[i*8 +: 8] = (i < lanes) ? din[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pdisp_stream.sv
module pdisp_stream
  import pdisp_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_mode,
  input  logic [PW-1:0] cfg_period,
  input  logic          irq_clr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          pnl_ready,
  output logic [DW-1:0] pnl_data,
  output logic          pnl_wr,
  output logic          busy,
  output logic          irq
);
  pd_state_t     state;
  logic [CW-1:0] remaining;
  logic [1:0]    mode_q;
  logic [PW-1:0] period_q;
  logic          tick;
  logic          restart;
  logic [DW-1:0] packed_word;
  logic          can_rise;

  pdisp_phase_timer #(.PW(PW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .period  (period_q),
    .tick    (tick)
  );

  pdisp_bus_pack #(.DW(DW)) u_pack (
    .din  (mem_rdata),
    .mode (mode_q),
    .dout (packed_word)
  );

  assign can_rise = (remaining != '0) && pnl_ready;

  always_comb begin
    restart = 1'b0;
    case (state)
      ST_FETCH: restart = 1'b1;
      ST_LOW:   restart = tick && ((remaining == '0) || pnl_ready);
      ST_HIGH:  restart = tick;
      default:  restart = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      remaining <= '0;
      mode_q    <= '0;
      period_q  <= '0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      pnl_data  <= '0;
      pnl_wr    <= 1'b0;
      busy      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (cfg_count == '0) begin
              irq <= 1'b1;
            end else begin
              busy      <= 1'b1;
              mem_rd    <= 1'b1;
              mem_addr  <= cfg_addr;
              remaining <= cfg_count;
              mode_q    <= cfg_mode;
              period_q  <= cfg_period;
              state     <= ST_FETCH;
            end
          end
        end
        ST_FETCH: state <= ST_LOW;
        ST_LOW: begin
          if (tick) begin
            if (remaining == '0) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              irq   <= 1'b1;
            end else if (can_rise) begin
              state     <= ST_HIGH;
              pnl_wr    <= 1'b1;
              pnl_data  <= packed_word;
              remaining <= remaining - 1'b1;
              if (remaining != CW'(1)) begin
                mem_rd   <= 1'b1;
                mem_addr <= mem_addr + 1'b1;
              end
            end
          end
        end
        ST_HIGH: begin
          if (tick) begin
            pnl_wr <= 1'b0;
            state  <= ST_LOW;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdisp_stream_chk.sv
module pdisp_stream_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_clr,
  input logic          mem_rd,
  input logic          pnl_ready,
  input logic [DW-1:0] pnl_data,
  input logic          pnl_wr,
  input logic          busy,
  input logic          irq
);
  assert_strobe_in_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pnl_wr) |-> busy);

  assert_read_in_run_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  assert_data_moves_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(pnl_data) |-> $rose(pnl_wr));

  assert_rise_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pnl_wr) |-> $past(pnl_ready));

  assert_done_raises_irq_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(irq) && !$past(irq_clr)) |-> irq);
endmodule

bind pdisp_stream pdisp_stream_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_clr   (irq_clr),
  .mem_rd    (mem_rd),
  .pnl_ready (pnl_ready),
  .pnl_data  (pnl_data),
  .pnl_wr    (pnl_wr),
  .busy      (busy),
  .irq       (irq)
);

// File: tb/pdisp_stream_tb.sv
module pdisp_stream_tb;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0]    cfg_mode = '0;
  logic [PW-1:0] cfg_period = '0;
  logic          irq_clr = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          pnl_ready = 1'b1;
  logic [DW-1:0] pnl_data;
  logic          pnl_wr;
  logic          busy;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pdisp_stream #(.DW(DW), .AW(AW), .CW(CW), .PW(PW)) u_dut (.*);

  function automatic logic [31:0] memval(logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] + 8'h11, ~a[7:0], a[7:0] ^ a[15:8]};
  endfunction

  function automatic logic [31:0] masked(logic [31:0] v, logic [1:0] m);
    case (m)
      2'd0:    return {24'h0, v[7:0]};
      2'd1:    return {16'h0, v[15:0]};
      default: return v;
    endcase
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= memval(mem_addr);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Run monitor state
  logic [15:0] exp_base = '0;
  logic [1:0]  exp_mode = '0;
  int          exp_per = 0;
  int          idx = 0;
  int          reads = 0;
  bit          chk_lo = 1'b1;
  bit          prev_wr = 1'b0;
  bit          prev_busy = 1'b0;
  int          hi_len = 0;
  int          lo_len = 0;

  always @(posedge clk) if (!rst && mem_rd) reads++;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_busy && !busy && idx > 0)  // R8 completion delay
        chk(lo_len == exp_per + 1, "R8 completion delay", lo_len, exp_per + 1);
      if (pnl_wr && !prev_wr) begin
        chk(pnl_data == masked(memval(exp_base + 16'(idx)), exp_mode),
            "R3/R6 word value", pnl_data, masked(memval(exp_base + 16'(idx)), exp_mode));
        if (idx > 0 && chk_lo)
          chk(lo_len == exp_per + 1, "R5 low phase", lo_len, exp_per + 1);
        idx++;
        hi_len = 1;
      end else if (!pnl_wr && prev_wr) begin
        chk(hi_len == exp_per + 1, "R5 high phase", hi_len, exp_per + 1);
        lo_len = 1;
      end else if (pnl_wr) begin
        hi_len++;
      end else begin
        lo_len++;
      end
      prev_wr = pnl_wr;
      prev_busy = busy;
    end
  end

  task automatic kick(input logic [15:0] a, input int n, input logic [1:0] m, input int p);
    @(negedge clk);
    exp_base = a; exp_mode = m; exp_per = p; idx = 0; reads = 0;
    cfg_addr = a; cfg_count = CW'(n); cfg_mode = m; cfg_period = PW'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int guard = 0;
    while (busy && guard < 5000) begin
      if (irq) chk(1'b0, {tag, " R8 irq during run"}, irq, 0);
      @(negedge clk);
      guard++;
    end
    chk(!busy, {tag, " R2 run ends"}, busy, 0);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  // addr[29:14], count[13:6], mode[5:4], period[3:0]
  localparam logic [29:0] VEC [0:5] = '{
    {16'h0000, 8'd4, 2'd1, 4'd0},
    {16'h0100, 8'd5, 2'd0, 4'd1},
    {16'h0FFE, 8'd3, 2'd2, 4'd2},
    {16'h0020, 8'd1, 2'd3, 4'd0},
    {16'h0300, 8'd8, 2'd1, 4'd3},
    {16'hFFFE, 8'd4, 2'd2, 4'd1}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pnl_wr == 0 && pnl_data == 0 && mem_rd == 0 && busy == 0 && irq == 0,
        "R1 reset outputs", {pnl_wr, mem_rd, busy, irq}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      int n;
      n = int'(VEC[v][13:6]);
      kick(VEC[v][29:14], n, VEC[v][5:4], int'(VEC[v][3:0]));
      chk(busy, "R2 busy after start", busy, 1);
      wait_done("vector");
      chk(idx == n, "R3 strobe count", idx, n);
      chk(reads == n, "R3 read count", reads, n);
      chk(irq, "R8 irq at end", irq, 1);
      clear_irq();
      chk(!irq, "R10 irq cleared", irq, 0);
    end

    // R9 zero count
    kick(16'h0500, 0, 2'd2, 0);
    chk(irq && !busy, "R9 zero count completes", {irq, busy}, 2'b10);
    repeat (5) @(negedge clk);
    chk(idx == 0 && reads == 0, "R9 no strobe or read", idx + reads, 0);
    chk(irq, "R10 irq held without clear", irq, 1);
    clear_irq();

    // R2 start while busy is ignored
    kick(16'h0040, 6, 2'd1, 1);
    repeat (4) @(negedge clk);
    cfg_addr = 16'h0900; cfg_count = 16'd2; cfg_mode = 2'd0; cfg_period = 12'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("restart");
    chk(idx == 6, "R2 second start ignored", idx, 6);
    clear_irq();

    // R7 ready stall
    pnl_ready = 1'b0;
    chk_lo = 1'b0;
    kick(16'h0200, 3, 2'd2, 0);
    repeat (15) @(negedge clk);
    chk(idx == 0 && busy, "R7 stall holds strobe", idx, 0);
    pnl_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    pnl_ready = 1'b0;
    repeat (10) @(negedge clk);
    chk(idx == 1 && !pnl_wr, "R7 stall after first word", idx, 1);
    pnl_ready = 1'b1;
    wait_done("ready");
    chk(idx == 3, "R7 all words after release", idx, 3);
    clear_irq();
    chk_lo = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule